// File: doc/BRIEF.md
# Device Interrupt Status Unit

This block collects event pulses from four sources of a display-style peripheral: line begin, line finish, frame begin and frame finish. Each pulse latches a sticky pending flag. A separate mask register picks which pending flags may raise the one level-sensitive interrupt request line. When every mask bit is zero, the peripheral can still be run by polling.

Software uses a simple strobe-and-address register port. It reads the pending flags and clears them by writing ones. The clear path is built so that an event arriving in the same clock as its clear is never lost. The request line stays high as long as any unmasked pending flag is set. This means it keeps asking for service until software has dealt with every enabled cause.

Top module: `irq_stat_unit`

## Requirements
- R1: A one-cycle pulse on `evt_i[k]` sets pending bit k at that clock edge. The bit mapping is: bit 0 line begin, bit 1 line finish, bit 2 frame begin, bit 3 frame finish.
- R2: A write to address 0 clears every pending bit whose write-data bit is 1. Pending bits whose write-data bit is 0 keep their value.
- R3: If an event and a write-one clear hit the same pending bit in the same cycle, the bit stays set.
- R4: `irq_o` is high exactly when at least one bit is set in both the pending register and the mask register. It follows either register with no extra cycle of delay.
- R5: Pending bits latch events whether or not the matching mask bit is set, so software can poll them.
- R6: With the mask register at zero, `irq_o` stays low while events are still captured into the pending register.
- R7: Once raised, `irq_o` stays high on idle cycles until software clears the enabled pending bits or masks them.
- R8: Register map: address 0 holds the pending flags (read, write-one-to-clear), and address 1 holds the mask (read/write). Only bits 3:0 are stored, and bits 31:4 read as 0. Addresses 2 and 3 read as 0, and writes to them change nothing.
- R9: After reset, the pending register and the mask register are both 0, and `irq_o` is low.
- R10: `rdata_o` is loaded at the clock edge where `rd_i` is high. It holds its value on cycles where `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 4 | Event pulses, one per source, synchronous to clk_i |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Level-sensitive interrupt request |

## Verification
Event capture, clears and mask writes all take effect at the clock edge that samples them. Because `irq_o` is derived from registers only, it reflects that edge without any further cycle. Read data is registered, so it appears after the same edge that samples `rd_i`. The bench drives inputs on the falling edge and samples one nanosecond after the next rising edge, which is the first point where each result is due. Hold and ignore checks are made on later idle cycles through a fresh read.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int N_SRC  = 4;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PEND = 2'd0,
    REG_MASK = 2'd1
  } reg_addr_e;

  typedef enum int {
    SRC_LINE_BEG  = 0,
    SRC_LINE_END  = 1,
    SRC_FRAME_BEG = 2,
    SRC_FRAME_END = 3
  } src_idx_e;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bit_q <= 1'b0;
      else if (evt_i[k]) bit_q <= 1'b1;   // set beats clear
      else if (clr_i[k]) bit_q <= 1'b0;
    end
    assign pend_o[k] = bit_q;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (we_i) mask_q <= wdata_i;
  end
  assign mask_o = mask_q;
endmodule

// File: rtl/irq_rd_port.sv
module irq_rd_port
  import irq_stat_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 32,
  parameter int AW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [N-1:0]  pend_i,
  input  logic [N-1:0]  mask_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] rdata_q;

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      AW'(REG_PEND): rd_mux[N-1:0] = pend_i;
      AW'(REG_MASK): rd_mux[N-1:0] = mask_i;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end
  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_stat_unit.sv
module irq_stat_unit
  import irq_stat_pkg::*;
#(
  parameter int N  = N_SRC,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  evt_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] mask_q;
  logic [N-1:0] clr_vec;
  logic         wr_pend;
  logic         wr_mask;
  logic         wdata_unused;

  assign wr_pend      = wr_i && (addr_i == AW'(REG_PEND));
  assign wr_mask      = wr_i && (addr_i == AW'(REG_MASK));
  assign clr_vec      = wr_pend ? wdata_i[N-1:0] : '0;
  assign wdata_unused = ^wdata_i[DW-1:N];

  irq_pend_reg #(.N(N)) i_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .clr_i  (clr_vec),
    .pend_o (pend_q)
  );

  irq_mask_reg #(.N(N)) i_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_mask),
    .wdata_i (wdata_i[N-1:0]),
    .mask_o  (mask_q)
  );

  irq_rd_port #(.N(N), .DW(DW), .AW(AW)) i_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_i),
    .addr_i  (addr_i),
    .pend_i  (pend_q),
    .mask_i  (mask_q),
    .rdata_o (rdata_o)
  );

  assign irq_o = |(pend_q & mask_q);
endmodule

// File: rtl/irq_stat_chk.sv
module irq_stat_chk #(
  parameter int N  = 4,
  parameter int DW = 32,
  parameter int AW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  evt_i,
  input logic          wr_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic [N-1:0]  pend_q,
  input logic [N-1:0]  mask_q,
  input logic          irq_o
);
  AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((pend_q & $past(evt_i)) == $past(evt_i))); // R1

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == AW'(0)) |=> ((pend_q & $past(wdata_i[N-1:0] & ~evt_i)) == '0)); // R2

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|evt_i) && !(wr_i && addr_i == AW'(0))) |=> $stable(pend_q)); // R2

  AST_MASK_ZERO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o); // R6

  AST_IRQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !wr_i) |=> irq_o); // R7

  AST_MASK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == AW'(1)) |=> (mask_q == $past(wdata_i[N-1:0]))); // R8

  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DW-1:N] == '0); // R8
endmodule

bind irq_stat_unit irq_stat_chk #(.N(N), .DW(DW), .AW(AW)) i_irq_stat_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .evt_i   (evt_i),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pend_q  (pend_q),
  .mask_q  (mask_q),
  .irq_o   (irq_o)
);

// File: tb/test_irq_stat_unit.sv
module test_irq_stat_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  evt = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  irq_stat_unit i_irq_stat_unit (
    .clk_i (clk), .rst_ni (rst_n), .evt_i (evt), .wr_i (wr), .rd_i (rd),
    .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata), .irq_o (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    step();
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    step();
    d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] e);
    @(negedge clk); evt = e;
    step();
    @(negedge clk); evt = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R9 irq", {31'd0, irq}, 32'd0);
    reg_rd(2'd0, v); check("R9 pend", v, 32'd0);
    reg_rd(2'd1, v); check("R9 mask", v, 32'd0);
  endtask

  task automatic t_poll();
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      pulse(4'b1 << k);
      check("R6 irq low while masked", {31'd0, irq}, 32'd0);
      reg_rd(2'd0, v);
      check("R1 R5 pending bit set", v, 32'((1 << (k + 1)) - 1));
    end
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    reg_wr(2'd0, 32'h0);
    reg_rd(2'd0, v); check("R2 zero write keeps", v, 32'hF);
    reg_wr(2'd0, 32'h5);
    reg_rd(2'd0, v); check("R2 ones clear", v, 32'hA);
    reg_wr(2'd0, 32'hFFFF_FFFF);
    reg_rd(2'd0, v); check("R2 clear all", v, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    pulse(4'b0101);
    @(negedge clk); evt = 4'b0100; wr = 1'b1; addr = 2'd0; wdata = 32'h5;
    step();
    @(negedge clk); evt = '0; wr = 1'b0; wdata = '0;
    reg_rd(2'd0, v); check("R3 event beats clear", v, 32'h4);
    reg_wr(2'd0, 32'hF);
  endtask

  task automatic t_irq_level();
    logic [31:0] v;
    reg_wr(2'd1, 32'h8);
    check("R4 mask alone no irq", {31'd0, irq}, 32'd0);
    pulse(4'b0010);
    check("R4 unmasked-off source no irq", {31'd0, irq}, 32'd0);
    @(negedge clk); evt = 4'b1000;
    step();
    check("R4 irq same edge as event", {31'd0, irq}, 32'd1);
    @(negedge clk); evt = '0;
    repeat (5) step();
    check("R7 irq held while pending", {31'd0, irq}, 32'd1);
    reg_wr(2'd0, 32'h2);
    check("R7 irq held after other clear", {31'd0, irq}, 32'd1);
    @(negedge clk); wr = 1'b1; addr = 2'd0; wdata = 32'h8;
    step();
    check("R4 irq drops at clear edge", {31'd0, irq}, 32'd0);
    @(negedge clk); wr = 1'b0; wdata = '0;
    reg_rd(2'd0, v); check("R2 pending empty", v, 32'h0);
  endtask

  task automatic t_mask_off();
    logic [31:0] v;
    pulse(4'b1000);
    check("R4 irq raised", {31'd0, irq}, 32'd1);
    reg_wr(2'd1, 32'h0);
    check("R6 mask zero drops irq", {31'd0, irq}, 32'd0);
    pulse(4'b0001);
    check("R6 irq stays low", {31'd0, irq}, 32'd0);
    reg_rd(2'd0, v); check("R6 capture continues", v, 32'h9);
    reg_wr(2'd1, 32'h1);
    check("R4 re-enable raises irq", {31'd0, irq}, 32'd1);
    reg_wr(2'd1, 32'h0);
    reg_wr(2'd0, 32'hF);
  endtask

  task automatic t_map();
    logic [31:0] v;
    reg_wr(2'd1, 32'hFFFF_FFF6);
    reg_rd(2'd1, v); check("R8 mask upper bits zero", v, 32'h6);
    reg_wr(2'd2, 32'hF);
    reg_wr(2'd3, 32'hF);
    reg_rd(2'd1, v); check("R8 addr2/3 write ignored mask", v, 32'h6);
    reg_rd(2'd0, v); check("R8 addr2/3 write ignored pend", v, 32'h0);
    reg_rd(2'd2, v); check("R8 addr2 reads zero", v, 32'h0);
    reg_rd(2'd3, v); check("R8 addr3 reads zero", v, 32'h0);
    reg_rd(2'd1, v);
    @(negedge clk); addr = 2'd0; evt = 4'b0010;
    step();
    @(negedge clk); evt = '0;
    step();
    check("R10 rdata holds without strobe", rdata, 32'h6);
    check("R4 irq after masked-on event", {31'd0, irq}, 32'd1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_poll();
    t_w1c();
    t_collide();
    t_irq_level();
    t_mask_off();
    t_map();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule